// File: doc/BRIEF.md
# Prefix-Aware Addressing Mode Decoder

This block sits behind an instruction byte buffer of an 8-bit core with 16-bit index registers. It takes one byte per cycle and splits the stream into instructions. Each instruction is an optional prefix byte, one opcode byte and zero to four operand bytes. When the last byte of an instruction has been taken, the block pulses a done strobe. With that strobe it presents a descriptor giving:

- the instruction length;
- which index register the memory operand uses;
- which of the two index registers acts as the register operand;
- the addressing-mode class;
- the width of the address carried in the operand bytes.

Four prefix values change how the following opcode is read. One prefix exchanges the two index registers. Two prefixes turn the long offset-indexed row into a pointer-indirect form through a byte address, indexed by the first or the second register. One prefix selects an extended opcode space with 16-bit pointer indirection and 16-bit bit-operation addresses. Full operation decode, the fetching of pointers and execution are left to later stages.

Top module: `apd_decoder`

## Requirements
- R1: While reset is asserted, and until the synchronised reset has been released, `dsc_done` is 0 and `in_ready` is 0. After that, `in_ready` is 1.
- R2: A byte is taken on a rising edge where `in_valid` and `in_ready` are both 1. `dsc_done` is 1 for exactly the cycle after the edge that took the last byte of an instruction, and is 0 in every other cycle.
- R3: `dsc_len` equals the number of operand bytes, plus 1 for the opcode, plus 1 if a prefix was present. It ranges from 1 to 6.
- R4: An unprefixed opcode whose upper nibble is 0x0 or 0x1 is stack-relative (`dsc_mode`=5). It has one operand byte and an 8-bit address (`dsc_awid`=1). With prefix 0x90, 0x91 or 0x92, these rows have no operand bytes and mode none (0).
- R5: Prefixes 0x90 and 0x91 invert both `dsc_reg_y` and `dsc_idx_y` relative to the unprefixed values. The index flag is only ever 1 for the indexed modes (2, 3, 4).
- R6: Prefix 0x92 on an upper-nibble-0xD opcode gives byte-pointer indirect mode (3), indexed by X (`dsc_idx_y`=0). It has one operand byte and `dsc_awid`=1.
- R7: Prefix 0x91 on an upper-nibble-0xD opcode gives mode 3 indexed by Y (`dsc_idx_y`=1), with one operand byte.
- R8: Prefix 0x72 sets `dsc_ext`=1. On an upper-nibble-0xD opcode it gives word-pointer indirect mode (4), indexed by X, with two operand bytes and `dsc_awid`=2.
- R9: For an indexed mode with an opcode low nibble of 0x3 (word compare) or 0xE (word load), the register operand defaults to Y (`dsc_reg_y`=1). For every other opcode the default is X. Prefix 0x90 then swaps both register and index.
- R10: With prefix 0x72, upper-nibble-0x0/0x1 opcodes are bit operations in direct mode (1) with a 16-bit address (2 bytes, `dsc_awid`=2). Upper-nibble-0x5 opcodes are direct with four operand bytes.
- R11: A prefix byte received while a prefix is pending ends the attempt. It produces a descriptor with `dsc_illegal`=1, `dsc_len`=2, mode 0 and `dsc_ext`=0. The next byte is then decoded as a fresh first byte.
- R12: Cycles with `in_valid`=0 take no byte and leave the decode state unchanged, whatever `in_data` holds.
- R13: The other rows decode as follows, for all prefixes except the cases above:
  - 0xB: direct, 1 byte, width 1.
  - 0xC: direct, 2 bytes, width 2.
  - 0xD: offset-indexed (2), 2 bytes, width 2.
  - 0xE: offset-indexed, 1 byte, width 1.
  - 0xF: offset-indexed, no bytes, width 0.
  - All remaining rows: mode 0, no bytes, width 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is offered |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Block takes a byte this cycle |
| dsc_done | output | 1 | Descriptor valid strobe |
| dsc_len | output | 3 | Instruction length in bytes |
| dsc_reg_y | output | 1 | Register operand is Y (else X) |
| dsc_idx_y | output | 1 | Memory operand indexed by Y (else X) |
| dsc_mode | output | 3 | 0 none, 1 direct, 2 offset-indexed, 3 byte-pointer indirect, 4 word-pointer indirect, 5 stack-relative |
| dsc_awid | output | 2 | Address width: 0 none, 1 byte, 2 word |
| dsc_ext | output | 1 | Extended opcode space |
| dsc_illegal | output | 1 | Double prefix detected |

## Verification
Every descriptor field and the done strobe are registered once. They are therefore due in the cycle right after the edge that takes the final byte. An instruction with no operand bytes produces them one cycle after its opcode is taken. An illegal pair produces them one cycle after its second prefix is taken. The bench drives one byte at each falling edge and waits for the rising edge. It samples at the following falling edge, so every comparison sees exactly the state after one transfer. On every cycle the done strobe is compared with the bench's own stream model. That comparison covers idle cycles, which must show no strobe.

// File: rtl/apd_pkg.sv
package apd_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 3;
  localparam int MAX_OPND = 4;

  localparam logic [BYTE_W-1:0] PFX_EXT   = 8'h72;
  localparam logic [BYTE_W-1:0] PFX_SWAP  = 8'h90;
  localparam logic [BYTE_W-1:0] PFX_IND_Y = 8'h91;
  localparam logic [BYTE_W-1:0] PFX_IND_X = 8'h92;

  typedef enum logic [2:0] {
    AM_NONE   = 3'd0,
    AM_DIRECT = 3'd1,
    AM_OFFIDX = 3'd2,
    AM_PTR8   = 3'd3,
    AM_PTR16  = 3'd4,
    AM_SPREL  = 3'd5
  } amode_e;

  typedef struct packed {
    logic             illegal;
    logic             ext;
    logic [1:0]       awid;
    logic             reg_y;
    logic             idx_y;
    amode_e           mode;
    logic [LEN_W-1:0] len;
  } desc_t;

  function automatic logic is_prefix(input logic [BYTE_W-1:0] b);
    return (b == PFX_EXT) || (b == PFX_SWAP) ||
           (b == PFX_IND_Y) || (b == PFX_IND_X);
  endfunction
endpackage

// File: rtl/apd_rst_sync.sv
module apd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/apd_classify.sv
module apd_classify
  import apd_pkg::*;
(
  input  logic              pfx_vld,
  input  logic [BYTE_W-1:0] pfx,
  input  logic [BYTE_W-1:0] opc,
  output desc_t             desc,
  output logic [LEN_W-1:0]  nops
);
  logic       p_ext, p_swap, p_iy, p_ix, swap, word_op, indexed;
  logic [3:0] row;
  amode_e     mode;
  logic [1:0] awid;

  assign p_ext   = pfx_vld && (pfx == PFX_EXT);
  assign p_swap  = pfx_vld && (pfx == PFX_SWAP);
  assign p_iy    = pfx_vld && (pfx == PFX_IND_Y);
  assign p_ix    = pfx_vld && (pfx == PFX_IND_X);
  assign swap    = p_swap | p_iy;
  assign row     = opc[7:4];
  assign word_op = (opc[3:0] == 4'h3) || (opc[3:0] == 4'hE);

  always_comb begin
    mode = AM_NONE;
    nops = '0;
    awid = 2'd0;
    unique case (row)
      4'h0, 4'h1: begin
        if (!pfx_vld) begin
          mode = AM_SPREL;  nops = 3'd1; awid = 2'd1;
        end else if (p_ext) begin
          mode = AM_DIRECT; nops = 3'd2; awid = 2'd2;
        end
      end
      4'h5: begin
        if (p_ext) begin
          mode = AM_DIRECT; nops = 3'(MAX_OPND); awid = 2'd2;
        end
      end
      4'hB: begin mode = AM_DIRECT; nops = 3'd1; awid = 2'd1; end
      4'hC: begin mode = AM_DIRECT; nops = 3'd2; awid = 2'd2; end
      4'hD: begin
        if (p_ext) begin
          mode = AM_PTR16;  nops = 3'd2; awid = 2'd2;
        end else if (p_iy || p_ix) begin
          mode = AM_PTR8;   nops = 3'd1; awid = 2'd1;
        end else begin
          mode = AM_OFFIDX; nops = 3'd2; awid = 2'd2;
        end
      end
      4'hE: begin mode = AM_OFFIDX; nops = 3'd1; awid = 2'd1; end
      4'hF: begin mode = AM_OFFIDX; nops = 3'd0; awid = 2'd0; end
      default: ;
    endcase
  end

  assign indexed = (mode == AM_OFFIDX) || (mode == AM_PTR8) || (mode == AM_PTR16);

  always_comb begin
    desc.illegal = 1'b0;
    desc.ext     = p_ext;
    desc.awid    = awid;
    desc.reg_y   = (indexed && word_op) ^ swap;
    desc.idx_y   = indexed && swap;
    desc.mode    = mode;
    desc.len     = nops + 3'd1 + {2'b00, pfx_vld};
  end
endmodule

// File: rtl/apd_desc_reg.sv
module apd_desc_reg
  import apd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  desc_t d,
  output desc_t q,
  output logic  done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      done <= 1'b0;
    end else begin
      done <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/apd_decoder.sv
module apd_decoder
  import apd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       dsc_done,
  output logic [2:0] dsc_len,
  output logic       dsc_reg_y,
  output logic       dsc_idx_y,
  output logic [2:0] dsc_mode,
  output logic [1:0] dsc_awid,
  output logic       dsc_ext,
  output logic       dsc_illegal
);
  typedef enum logic [1:0] {S_FIRST, S_OPC, S_OPND} st_e;

  logic              srst_n, fire, emit;
  st_e               st_q, st_n;
  logic [BYTE_W-1:0] pfx_q, pfx_n;
  logic [LEN_W-1:0]  rem_q, rem_n, cls_nops;
  desc_t             hold_q, hold_n, cls_desc, emit_desc, out_q;
  logic              rdy_q;

  apd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(srst_n)
  );

  apd_classify u_cls (
    .pfx_vld(st_q == S_OPC), .pfx(pfx_q), .opc(in_data),
    .desc(cls_desc), .nops(cls_nops)
  );

  assign fire = in_valid && rdy_q;

  always_comb begin
    st_n      = st_q;
    pfx_n     = pfx_q;
    rem_n     = rem_q;
    hold_n    = hold_q;
    emit      = 1'b0;
    emit_desc = hold_q;
    if (fire) begin
      unique case (st_q)
        S_FIRST, S_OPC: begin
          if (is_prefix(in_data)) begin
            if (st_q == S_FIRST) begin
              pfx_n = in_data;
              st_n  = S_OPC;
            end else begin
              emit              = 1'b1;
              emit_desc         = '0;
              emit_desc.illegal = 1'b1;
              emit_desc.len     = 3'd2;
              st_n              = S_FIRST;
            end
          end else if (cls_nops == '0) begin
            emit      = 1'b1;
            emit_desc = cls_desc;
            st_n      = S_FIRST;
          end else begin
            hold_n = cls_desc;
            rem_n  = cls_nops;
            st_n   = S_OPND;
          end
        end
        S_OPND: begin
          if (rem_q == 3'd1) begin
            emit = 1'b1;
            st_n = S_FIRST;
          end
          rem_n = rem_q - 3'd1;
        end
        default: st_n = S_FIRST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= S_FIRST;
      pfx_q  <= '0;
      rem_q  <= '0;
      hold_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      if (fire) begin
        st_q   <= st_n;
        pfx_q  <= pfx_n;
        rem_q  <= rem_n;
        hold_q <= hold_n;
      end
    end
  end

  apd_desc_reg u_out (
    .clk(clk), .rst_n(srst_n), .load(emit), .d(emit_desc),
    .q(out_q), .done(dsc_done)
  );

  assign in_ready    = rdy_q;
  assign dsc_len     = out_q.len;
  assign dsc_reg_y   = out_q.reg_y;
  assign dsc_idx_y   = out_q.idx_y;
  assign dsc_mode    = out_q.mode;
  assign dsc_awid    = out_q.awid;
  assign dsc_ext     = out_q.ext;
  assign dsc_illegal = out_q.illegal;
endmodule

// File: rtl/apd_checker.sv
module apd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       dsc_done,
  input logic [2:0] dsc_len,
  input logic       dsc_reg_y,
  input logic       dsc_idx_y,
  input logic [2:0] dsc_mode,
  input logic [1:0] dsc_awid,
  input logic       dsc_ext,
  input logic       dsc_illegal
);
  // R2
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_done |-> $past(in_valid && in_ready));

  // R3
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_done && !dsc_illegal) |-> (dsc_len >= 3'd1 && dsc_len <= 3'd6));

  // R11
  illegal_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_done && dsc_illegal) |-> (dsc_len == 3'd2 && dsc_mode == 3'd0 && !dsc_ext));

  // R4
  sprel_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_done && dsc_mode == 3'd5) |-> (dsc_len == 3'd2 && dsc_awid == 2'd1 && !dsc_ext));

  // R8
  ptr16_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_done && dsc_mode == 3'd4) |-> (dsc_ext && dsc_len == 3'd4 && dsc_awid == 2'd2 && !dsc_idx_y));

  // R6
  ptr8_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_done && dsc_mode == 3'd3) |-> (dsc_len == 3'd3 && dsc_awid == 2'd1 && !dsc_ext));

  // R5
  idx_only_indexed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_done && dsc_idx_y) |-> (dsc_mode == 3'd2 || dsc_mode == 3'd3 || dsc_mode == 3'd4));

  // R12
  idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> !dsc_done);

  logic unused_ok;
  assign unused_ok = dsc_reg_y;
endmodule

bind apd_decoder apd_checker u_chk (.*);

// File: tb/tb_apd_decoder.sv
`timescale 1ns/1ps
module tb_apd_decoder;
  logic       clk, rst_n, in_valid;
  logic [7:0] in_data;
  logic       in_ready, dsc_done, dsc_reg_y, dsc_idx_y, dsc_ext, dsc_illegal;
  logic [2:0] dsc_len, dsc_mode;
  logic [1:0] dsc_awid;

  int checks = 0, errors = 0;
  bit finished = 0;

  apd_decoder dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // model state
  int         mst = 0, mrem = 0;
  logic [7:0] mp = 8'h00;
  logic [11:0] mhold = '0;
  logic [7:0] lastp = 8'h00;
  bit         lastpv = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit ispfx(input logic [7:0] b);
    return b == 8'h72 || b == 8'h90 || b == 8'h91 || b == 8'h92;
  endfunction

  // packing: {ill, ext, awid[1:0], reg_y, idx_y, mode[2:0], len[2:0]}
  function automatic logic [11:0] model(input bit pv, input logic [7:0] p,
                                         input logic [7:0] o, output int n);
    bit x72 = pv && p == 8'h72;
    bit sw  = pv && (p == 8'h90 || p == 8'h91);
    bit ind = pv && (p == 8'h91 || p == 8'h92);
    int m = 0, w = 0;
    bit ry, iy, ix;
    n = 0;
    if (o[7:4] <= 4'h1) begin
      if (!pv) begin m = 5; n = 1; w = 1; end
      else if (x72) begin m = 1; n = 2; w = 2; end
    end else if (o[7:4] == 4'h5) begin
      if (x72) begin m = 1; n = 4; w = 2; end
    end else if (o[7:4] == 4'hB) begin m = 1; n = 1; w = 1; end
    else if (o[7:4] == 4'hC) begin m = 1; n = 2; w = 2; end
    else if (o[7:4] == 4'hD) begin
      if (x72) begin m = 4; n = 2; w = 2; end
      else if (ind) begin m = 3; n = 1; w = 1; end
      else begin m = 2; n = 2; w = 2; end
    end else if (o[7:4] == 4'hE) begin m = 2; n = 1; w = 1; end
    else if (o[7:4] == 4'hF) begin m = 2; n = 0; w = 0; end
    ix = (m == 2 || m == 3 || m == 4);
    ry = ix && (o[3:0] == 4'h3 || o[3:0] == 4'hE);
    if (sw) ry = !ry;
    iy = ix && sw;
    return {1'b0, x72, w[1:0], ry, iy, m[2:0], 3'(n + 1 + int'(pv))};
  endfunction

  task automatic cyc(input bit v, input logic [7:0] b);
    bit ed = 0;
    logic [11:0] d = '0;
    int n;
    in_valid = v;
    in_data  = b;
    if (v && in_ready) begin
      if (mst == 2) begin
        mrem--;
        if (mrem == 0) begin ed = 1; d = mhold; mst = 0; end
      end else if (ispfx(b)) begin
        if (mst == 0) begin mst = 1; mp = b; end
        else begin ed = 1; d = 12'h802; mst = 0; lastpv = 0; end
      end else begin
        lastpv = (mst == 1); lastp = mp;
        d = model(mst == 1, mp, b, n);
        if (n == 0) begin ed = 1; mst = 0; end
        else begin mhold = d; mrem = n; mst = 2; d = '0; end
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(dsc_done == ed, v ? "R2" : "R12", dsc_done, ed);
    if (ed) begin
      string mt, rt;
      if (d[11]) mt = "R11";
      else if (d[5:3] == 3'd5 || (d[5:3] == 0 && !d[10] && d[9:8] == 0 && lastpv)) mt = "R4";
      else if (d[5:3] == 3'd3) mt = d[6] ? "R7" : "R6";
      else if (d[5:3] == 3'd4) mt = "R8";
      else if (d[10]) mt = "R10";
      else mt = "R13";
      rt = (lastpv && (lastp == 8'h90 || lastp == 8'h91)) ? "R5" : "R9";
      chk(dsc_len == d[2:0], "R3", dsc_len, d[2:0]);
      chk(dsc_mode == d[5:3], mt, dsc_mode, d[5:3]);
      chk(dsc_awid == d[9:8], mt, dsc_awid, d[9:8]);
      chk(dsc_reg_y == d[7], rt, dsc_reg_y, d[7]);
      chk(dsc_idx_y == d[6], rt, dsc_idx_y, d[6]);
      chk(dsc_ext == d[10], "R8", dsc_ext, d[10]);
      chk(dsc_illegal == d[11], "R11", dsc_illegal, d[11]);
    end
  endtask

  task automatic seq(input logic [7:0] bs[]);
    foreach (bs[i]) cyc(1'b1, bs[i]);
  endtask

  function automatic logic [7:0] gen_byte();
    int r = $urandom_range(0, 99);
    logic [3:0] rows[10] = '{4'h0, 4'h1, 4'h2, 4'h5, 4'h7, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF};
    logic [3:0] lo;
    if (mst == 2) return 8'($urandom);
    if (r < 22) begin
      case ($urandom_range(0, 3))
        0: return 8'h72;
        1: return 8'h90;
        2: return 8'h91;
        default: return 8'h92;
      endcase
    end
    r = $urandom_range(0, 2);
    lo = (r == 0) ? 4'h3 : (r == 1) ? 4'hE : 4'($urandom);
    return {rows[$urandom_range(0, 9)], lo};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    in_valid = 0; in_data = 8'h00; rst_n = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(dsc_done == 1'b0, "R1", dsc_done, 0);
    chk(in_ready == 1'b0, "R1", in_ready, 0);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R1", in_ready, 0);
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    chk(dsc_done == 1'b0, "R1", dsc_done, 0);

    seq('{8'h03, 8'h07});                    // R4 stack relative
    seq('{8'h90, 8'h15});                    // R4 prefixed row 1 -> none
    seq('{8'hDE, 8'h12, 8'h34});             // R9 word load default Y
    seq('{8'h90, 8'hDE, 8'h12, 8'h34});      // R5 swap
    seq('{8'h92, 8'hD3, 8'h44});             // R6
    seq('{8'h91, 8'hD3, 8'h44});             // R7
    seq('{8'h72, 8'hD6, 8'h11, 8'h22});      // R8
    seq('{8'h72, 8'h15, 8'h50, 8'h00});      // R10 bit op
    seq('{8'h72, 8'h55, 8'h01, 8'h02, 8'h03, 8'h04}); // R10 four operands
    seq('{8'h90, 8'h92, 8'hB5, 8'h10});      // R11 then resync
    seq('{8'h72, 8'h72, 8'hF3});             // R11 then one-byte op
    seq('{8'hC3, 8'h11});
    cyc(1'b0, 8'h90); cyc(1'b0, 8'hD6); cyc(1'b0, 8'h72); // R12 idle noise
    cyc(1'b1, 8'h22);                        // completes C3 11 22
    seq('{8'hF3, 8'hAE, 8'h2A, 8'hE3, 8'h72}); // R13 rows
    cyc(1'b1, 8'hB1); cyc(1'b1, 8'h00);

    for (int k = 0; k < 6000; k++) begin
      if ($urandom_range(0, 4) == 0) cyc(1'b0, 8'($urandom));
      else cyc(1'b1, gen_byte());
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8ns * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule